// File: doc/BRIEF.md
# MDIO Management Master with Presence Polling

This block is the host side of a two-wire station management link to external Ethernet PHYs. Software puts a transaction into a single 32-bit access register: direction, PHY address, register address and write data, with a start bit. The block then builds a Clause 22 frame, clocks it out on MDC and MDIO, and turns the line around for reads. When the frame ends it clears the start bit and reports the read data. It also reports whether a PHY drove the acknowledge slot.

When no software request is waiting, the block sends background reads of register 1 to addresses 0 through 31 in turn. Each reply, or the lack of one, updates one bit of a 32-bit presence map. Software can therefore see which addresses hold a working PHY without issuing any reads of its own.

MDC is derived from the system clock through a parameterised half-period divider. The default is 25 system clocks per half period, which gives 2 MHz from 100 MHz and so stays below the 2.5 MHz limit. MDC stays low for a programmable number of cycles after reset so that the PHYs can finish their own reset first. DIV_HALF must be at least 2.

Top module: `mdio_master`

## Requirements
- R1: Writing the access register (reg_sel=0) with bit 31 (start) set launches one transaction using the fields in that write. The fields are bit 30 direction (1=write), bits 25:21 register address and bits 20:16 PHY address. The register keeps those fields, and bit 31 reads 1 until the frame has ended and 0 afterwards.
- R2: Each frame is sent MSB first, in this order: 32 ones, start 01, opcode 10 (read) or 01 (write), the 5-bit PHY address, the 5-bit register address, turnaround, and 16 data bits. A write frame sends turnaround 10 followed by data bits 15:0. A PHY that decodes the frame stores that data.
- R3: On a read the block releases MDIO (mdio_oe=0) for turnaround and for the data bits. Bit 29 (ACK) is set only if the second turnaround bit was sampled low. A line pulled high therefore gives ACK=0. A write completes with ACK=0.
- R4: After a read completes, bits 15:0 of the access register hold the 16 data bits sampled from MDIO, first bit as the MSB.
- R5: The presence map (reg_sel=1) has one bit per PHY address. Bit n equals the ACK of the most recent read of address n. Background reads of register 1 cycle through addresses 0 to 31 whenever no request is pending.
- R6: A pending request wins at the next frame boundary. Its start bit therefore clears within two frame times (2 x 64 MDC periods) after it is written.
- R7: Once running, MDC toggles every DIV_HALF system clocks, so its period is 2 x DIV_HALF clocks.
- R8: MDC stays low, with no edge, for STARTUP_CYCLES system clocks after reset is released.
- R9: mdio_o and mdio_oe change only together with a falling edge of MDC. MDIO is sampled at the rising edge.
- R10: A write to the access register while its start bit is set has no effect. Writes to the presence map have no effect.
- R11: After reset both registers read 0, and mdc and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the access register, 1 the presence map |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is the acknowledge decision. It depends on which side drives the line during the second turnaround slot, and it has to be checked both for a PHY that answers and for one that is missing while the line floats high. The bench contains a PHY model that decodes each frame from the MDC and MDIO pins and answers only at the addresses in a presence mask. It pulls the line high otherwise. Reads are swept over all 32 addresses at the identifier registers, and the mask is changed between background sweeps, so that every presence bit is seen both to set and to clear. A request written on the cycle after another request exercises the rule that writes are ignored while a transaction is in flight.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef struct packed {
        logic        go;
        logic        wr;
        logic        ack;
        logic [2:0]  rsvd;
        logic [4:0]  regad;
        logic [4:0]  phyad;
        logic [15:0] data;
    } uacc_t;

    localparam int           FRAME_BITS = 64;
    localparam logic [5:0]   TA_FIRST   = 6'd46;
    localparam logic [5:0]   TA_SECOND  = 6'd47;
    localparam logic [5:0]   DATA_FIRST = 6'd48;
    localparam logic [5:0]   LAST_BIT   = 6'd63;
    localparam logic [1:0]   OP_RD      = 2'b10;
    localparam logic [1:0]   OP_WR      = 2'b01;
    localparam logic [4:0]   POLL_REG   = 5'd1;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF    = 25,
    parameter int STARTUP = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int SW = $clog2(STARTUP + 1);
    localparam int DW = $clog2(HALF + 1);

    typedef struct packed {
        logic [SW-1:0] wait_cnt;
        logic          run;
        logic [DW-1:0] div;
        logic          mdc;
    } st_t;

    st_t  s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = s_q.run && (s_q.div == DW'(HALF - 1));
        if (!s_q.run) begin
            if (s_q.wait_cnt == SW'(STARTUP)) s_d.run = 1'b1;
            else s_d.wait_cnt = s_q.wait_cnt + 1'b1;
        end else if (wrap) begin
            s_d.div = '0;
            s_d.mdc = !s_q.mdc;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc       = s_q.mdc;
    assign rise_tick = wrap && !s_q.mdc;
    assign fall_tick = wrap &&  s_q.mdc;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        start,
    input  logic        rd,
    input  logic [4:0]  phyad,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    output logic        accept,
    output logic        done,
    output logic        ack,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  ack;
        logic [15:0]           rdata;
        logic                  done;
        logic                  out;
        logic                  oe;
    } st_t;

    st_t                   s_d, s_q;
    logic [FRAME_BITS-1:0] frame;
    logic [5:0]            idx_nx;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        idx_nx   = s_q.idx + 1'b1;
        frame    = {32'hFFFF_FFFF, 2'b01, (rd ? OP_RD : OP_WR), phyad, regad,
                    2'b10, (rd ? 16'h0000 : wdata)};
        if (fall_tick) begin
            if (!s_q.busy) begin
                s_d.oe  = start;
                s_d.out = start ? frame[FRAME_BITS-1] : 1'b0;
                if (start) begin
                    accept      = 1'b1;
                    s_d.busy    = 1'b1;
                    s_d.idx     = '0;
                    s_d.sh      = frame;
                    s_d.rd      = rd;
                    s_d.ack     = 1'b0;
                    s_d.rdata   = '0;
                end
            end else begin
                s_d.idx = idx_nx;
                s_d.sh  = {s_q.sh[FRAME_BITS-2:0], 1'b0};
                s_d.out = s_q.sh[FRAME_BITS-2];
                s_d.oe  = !(s_q.rd && (idx_nx >= TA_FIRST));
            end
        end
        if (rise_tick && s_q.busy) begin
            if (s_q.rd && (s_q.idx == TA_SECOND))  s_d.ack   = !mdio_i;
            if (s_q.rd && (s_q.idx >= DATA_FIRST)) s_d.rdata = {s_q.rdata[14:0], mdio_i};
            if (s_q.idx == LAST_BIT) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done    = s_q.done;
    assign ack     = s_q.ack;
    assign rdata   = s_q.rdata;
    assign mdio_o  = s_q.out;
    assign mdio_oe = s_q.oe;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF       = 25,
    parameter int STARTUP_CYCLES = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int NADDR = 32;

    typedef struct packed {
        uacc_t            ua;
        logic [NADDR-1:0] alive;
        logic [4:0]       poll_addr;
        logic             cur_user;
    } st_t;

    st_t         s_d, s_q;
    logic        rise_tick, fall_tick;
    logic        eng_accept, eng_done, eng_ack, eng_rd;
    logic [4:0]  eng_phy, eng_reg;
    logic [15:0] eng_rdata;
    logic        user_go;
    logic [31:0] alive_q;

    mdio_clkgen #(.HALF(DIV_HALF), .STARTUP(STARTUP_CYCLES)) u_clk (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    assign user_go = s_q.ua.go;
    assign alive_q = s_q.alive;
    assign eng_rd  = user_go ? !s_q.ua.wr  : 1'b1;
    assign eng_phy = user_go ? s_q.ua.phyad : s_q.poll_addr;
    assign eng_reg = user_go ? s_q.ua.regad : POLL_REG;

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .start(1'b1), .rd(eng_rd), .phyad(eng_phy), .regad(eng_reg),
        .wdata(s_q.ua.data), .accept(eng_accept), .done(eng_done),
        .ack(eng_ack), .rdata(eng_rdata),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always_comb begin
        s_d = s_q;
        if (eng_accept) s_d.cur_user = user_go;
        if (eng_done) begin
            if (s_q.cur_user) begin
                s_d.ua.go = 1'b0;
                if (!s_q.ua.wr) begin
                    s_d.ua.ack              = eng_ack;
                    s_d.ua.data             = eng_rdata;
                    s_d.alive[s_q.ua.phyad] = eng_ack;
                end
            end else begin
                s_d.alive[s_q.poll_addr] = eng_ack;
                s_d.poll_addr            = s_q.poll_addr + 1'b1;
            end
        end
        if (reg_wr && !reg_sel && !user_go) begin
            s_d.ua      = uacc_t'(reg_wdata);
            s_d.ua.ack  = 1'b0;
            s_d.ua.rsvd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = reg_sel ? s_q.alive : 32'(s_q.ua);
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_HALF       = 25,
    parameter int STARTUP_CYCLES = 100000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        user_go,
    input logic        eng_done,
    input logic [31:0] alive_q
);
    localparam int CW = $clog2(STARTUP_CYCLES + 2);
    localparam int HW = $clog2(DIV_HALF + 2);

    logic [CW-1:0] since_rst;
    logic [HW-1:0] hold;
    logic          mdc_prev, o_prev, oe_prev, seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            hold      <= '0;
            mdc_prev  <= 1'b0;
            o_prev    <= 1'b0;
            oe_prev   <= 1'b0;
            seen      <= 1'b0;
        end else begin
            if (since_rst != CW'(STARTUP_CYCLES + 1)) since_rst <= since_rst + 1'b1;
            if (mdc != mdc_prev) begin
                hold <= HW'(1);
                seen <= 1'b1;
            end else if (hold != HW'(DIV_HALF + 1)) begin
                hold <= hold + 1'b1;
            end
            mdc_prev <= mdc;
            o_prev   <= mdio_o;
            oe_prev  <= mdio_oe;
        end
    end

    p_mdc_quiet_startup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(STARTUP_CYCLES)) |-> !mdc);

    p_mdc_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (mdc != mdc_prev)) |-> (hold == HW'(DIV_HALF)));

    p_pins_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdio_o != o_prev) || (mdio_oe != oe_prev)) |-> (mdc_prev && !mdc));

    p_go_clears_on_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_go) |-> $past(eng_done));

    p_alive_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alive_q) |-> $past(eng_done));
endmodule

bind mdio_master mdio_master_chk #(
    .DIV_HALF(DIV_HALF), .STARTUP_CYCLES(STARTUP_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .user_go(user_go), .eng_done(eng_done), .alive_q(alive_q)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int DIV_HALF  = 2;
    localparam int STARTUP   = 40;
    localparam int FRAME_CYC = 64 * 2 * DIV_HALF;
    localparam int SWEEP_CYC = 2 * 32 * FRAME_CYC + 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    logic [31:0] present = 32'h8002_0402;
    logic [15:0] regs [32][32];
    int          n_chk = 0;
    int          n_fail = 0;
    int          pin_viol = 0;
    int          contention = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_master #(.DIV_HALF(DIV_HALF), .STARTUP_CYCLES(STARTUP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // PHY model: decodes frames from the pins, answers at present addresses
    initial begin
        for (int a = 0; a < 32; a++)
            for (int r = 0; r < 32; r++)
                regs[a][r] = 16'((a * 16'h0831) ^ (r * 16'h1F05) ^ 16'hA5C3);
        forever begin
            int          ones;
            logic [12:0] hdr;
            logic [15:0] wd;
            ones = 0;
            forever begin
                @(posedge mdc);
                if (mdio_i) ones++;
                else if (ones >= 32) break;
                else ones = 0;
            end
            hdr = '0;
            for (int i = 0; i < 13; i++) begin
                @(posedge mdc);
                hdr = {hdr[11:0], mdio_i};
            end
            if (hdr[11:10] == 2'b10) begin
                @(negedge mdc);
                if (present[hdr[9:5]]) begin
                    @(negedge mdc);
                    phy_en = 1'b1; phy_bit = 1'b0;
                    for (int i = 15; i >= 0; i--) begin
                        @(negedge mdc);
                        phy_bit = regs[hdr[9:5]][hdr[4:0]][i];
                    end
                    @(negedge mdc);
                    phy_en = 1'b0; phy_bit = 1'b1;
                end
            end else if (hdr[11:10] == 2'b01) begin
                @(posedge mdc); @(posedge mdc);
                wd = '0;
                for (int i = 0; i < 16; i++) begin
                    @(posedge mdc);
                    wd = {wd[14:0], mdio_i};
                end
                if (present[hdr[9:5]]) regs[hdr[9:5]][hdr[4:0]] = wd;
            end
        end
    end

    // pin timing monitor (R9) and drive contention monitor (R3)
    initial begin
        logic pm, po, poe;
        pm = 1'b0; po = 1'b0; poe = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (((mdio_o != po) || (mdio_oe != poe)) && !(pm && !mdc)) pin_viol++;
                if (mdio_oe && phy_en) contention++;
            end
            pm = mdc; po = mdio_o; poe = mdio_oe;
        end
    end

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic wait_go(output logic [31:0] d, output int cyc);
        cyc = 0;
        do begin
            rd_reg(1'b0, d);
            cyc++;
        end while (d[31] && cyc < 4 * FRAME_CYC);
    endtask

    task automatic xact(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, output logic [31:0] res, output int cyc);
        wr_reg(1'b0, {1'b1, wr, 1'b0, 3'b000, ra, pa, wd});
        wait_go(res, cyc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R6: actual 0x%08h expected 0x%08h", 32'd190000, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          cyc, mdc_hi;
        time         t1, t2;

        repeat (4) @(negedge clk);
        rd_reg(1'b0, d); chk(d == 0, "R11 access reg reset", d, 0);
        rd_reg(1'b1, d); chk(d == 0, "R11 presence reset", d, 0);
        chk({mdc, mdio_oe} == 2'b00, "R11 pins reset", {mdc, mdio_oe}, 0);
        @(negedge clk) rst_n = 1'b1;

        mdc_hi = 0;
        for (int i = 0; i < STARTUP; i++) begin
            @(negedge clk);
            if (mdc) mdc_hi++;
        end
        chk(mdc_hi == 0, "R8 mdc quiet after reset", mdc_hi, 0);

        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        chk((t2 - t1) / 10 == 2 * DIV_HALF, "R7 mdc period", 32'((t2 - t1) / 10), 2 * DIV_HALF);

        repeat (SWEEP_CYC) @(negedge clk);
        rd_reg(1'b1, d);
        chk(d == present, "R5 presence map sweep", d, present);

        for (int pa = 0; pa < 32; pa++) begin
            for (int ra = 2; ra <= 3; ra++) begin
                logic [31:0] exp;
                xact(1'b0, 5'(pa), 5'(ra), 16'h0, d, cyc);
                chk(!d[31], "R1 start clears", d, {1'b0, d[30:0]});
                chk(cyc <= 2 * FRAME_CYC + 16, "R6 request latency", cyc, 2 * FRAME_CYC + 16);
                chk(d[25:16] == {5'(ra), 5'(pa)}, "R1 fields kept", d[25:16], {5'(ra), 5'(pa)});
                chk(d[29] == present[pa], "R3 acknowledge", d[29], present[pa]);
                exp = present[pa] ? {16'h0, regs[pa][ra]} : 32'h0000_FFFF;
                chk(d[15:0] == exp[15:0], "R4 read data", d[15:0], exp[15:0]);
            end
        end

        xact(1'b1, 5'd10, 5'd4, 16'hBEEF, d, cyc);
        chk(!d[31] && !d[29], "R3 write completes with ACK=0", d, {16'h4000 | 16'h0, 16'h0});
        chk(regs[10][4] == 16'hBEEF, "R2 write frame stored", regs[10][4], 16'hBEEF);
        xact(1'b0, 5'd10, 5'd4, 16'h0, d, cyc);
        chk(d[15:0] == 16'hBEEF, "R4 readback of written data", d[15:0], 16'hBEEF);

        wr_reg(1'b0, {1'b1, 1'b0, 1'b0, 3'b000, 5'd2, 5'd1, 16'h0});
        wr_reg(1'b0, {1'b1, 1'b1, 1'b0, 3'b000, 5'd7, 5'd5, 16'h1234});
        wait_go(d, cyc);
        chk(d[30:16] == {1'b0, 1'b1, 3'b000, 5'd2, 5'd1}, "R10 write during start ignored",
            d[30:16], {1'b0, 1'b1, 3'b000, 5'd2, 5'd1});
        chk(d[15:0] == regs[1][2], "R10 first request data", d[15:0], regs[1][2]);
        chk(regs[5][7] != 16'h1234, "R10 no second frame", regs[5][7], regs[5][7] ^ 16'h1234);

        wr_reg(1'b1, 32'h0F0F_0F0F);
        rd_reg(1'b1, d);
        chk(d == present, "R10 presence map read-only", d, present);

        present = 32'h0000_0002;
        repeat (SWEEP_CYC) @(negedge clk);
        rd_reg(1'b1, d);
        chk(d == 32'h0000_0002, "R5 presence map after change", d, 32'h0000_0002);

        chk(pin_viol == 0, "R9 pins change on falling mdc", pin_viol, 0);
        chk(contention == 0, "R3 line released for reply", contention, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule